// File: doc/BRIEF.md
# PCI Interrupt Steering Router

The block maps four active-low, level-sensitive PCI interrupt inputs (A to D) onto a sixteen-line, active-high vector of legacy interrupt requests. Each input owns an 8-bit steering register. Software writes and reads these registers through a small port that selects a register with a 2-bit index.

Bit 7 of a register is a disable flag. When it is set, that input reaches no line. When it is clear, bits 3:0 choose the target line. The line codes are sparse: some codes are reserved, and an enabled route that holds a reserved code drives nothing. Inputs that target the same line are ORed together. The output vector is registered.

Top module: `irq_steer_router`

## Requirements
- R1: After reset, each of the four registers (index 0 = A, 1 = B, 2 = C, 3 = D) reads back 8'h80, and `irq_o` stays all zero whatever the inputs are.
- R2: When bit 7 of a register is 1, its input drives no bit of `irq_o`.
- R3: When bit 7 is 0 and bits 3:0 hold a code from {3,4,5,6,7,9,10,11,12,14,15}, a low level on that input sets `irq_o[code]`, and a high level clears it.
- R4: When bit 7 is 0 and bits 3:0 hold a code from {0,1,2,8,13}, the input drives no bit of `irq_o`.
- R5: Bits 6:4 of every register always read back as zero, whatever value was written.
- R6: When two or more enabled inputs target the same line, that line is 1 if any of those inputs is low.
- R7: A write with `cfg_wr_i` high takes effect at the clock edge where it is sampled. A read with `cfg_rd_i` high presents the register value on `cfg_rdata_o` after that same edge. `cfg_rdata_o` holds its value while `cfg_rd_i` is low.
- R8: `irq_o` is registered. It changes at the first clock edge after an input or a register changes, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_idx_i | input | 2 | Register index (0 = A .. 3 = D) |
| cfg_wr_i | input | 1 | Write strobe |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rd_i | input | 1 | Read strobe |
| cfg_rdata_o | output | 8 | Read data, reserved bits zero |
| pirq_ni | input | 4 | PCI interrupt inputs, active low |
| irq_o | output | 16 | Legacy IRQ lines, active high |

## Verification
Input A is routed to every valid code in turn while it is asserted and deasserted. A wrong entry in the code decode shows up as a missing bit or a bit at the wrong position. Each reserved code is then tried with the route enabled and the input asserted, which separates a decoder that filters reserved codes from one that only shifts a bit into place. Two inputs share one line and are asserted alone, together and not at all, which separates an OR of the inputs from an AND or from last-writer-wins. Probing the output just before and just after an edge pins down the one-cycle latency.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  parameter int NUM_SRC = 4;
  parameter int NUM_IRQ = 16;
  parameter int CODE_W  = 4;
  parameter int IDX_W   = $clog2(NUM_SRC);
  parameter int REG_W   = 8;
  // lines reachable through the code field; all other codes are reserved
  parameter logic [NUM_IRQ-1:0] VALID_MASK = 16'hDEF8;

  function automatic logic code_valid(input logic [CODE_W-1:0] c);
    return VALID_MASK[c];
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_steer_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [IDX_W-1:0]       cfg_idx_i,
  input  logic                   cfg_wr_i,
  input  logic [REG_W-1:0]       cfg_wdata_i,
  input  logic                   cfg_rd_i,
  output logic [REG_W-1:0]       cfg_rdata_o,
  output logic [NUM_SRC-1:0]     dis_o,
  output logic [NUM_SRC-1:0][CODE_W-1:0] code_o
);
  localparam int PAD_W = REG_W - 1 - CODE_W;

  logic [NUM_SRC-1:0]             dis_q;
  logic [NUM_SRC-1:0][CODE_W-1:0] code_q;
  logic [REG_W-1:0]               rdata_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dis_q[i]  <= 1'b1;
        code_q[i] <= '0;
      end else if (cfg_wr_i && cfg_idx_i == IDX_W'(i)) begin
        dis_q[i]  <= cfg_wdata_i[REG_W-1];
        code_q[i] <= cfg_wdata_i[CODE_W-1:0];
      end
    end
  end

  // only enable and code are stored; reserved bits are rebuilt as zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (cfg_rd_i) rdata_q <= {dis_q[cfg_idx_i], {PAD_W{1'b0}}, code_q[cfg_idx_i]};
  end

  assign cfg_rdata_o = rdata_q;
  assign dis_o       = dis_q;
  assign code_o      = code_q;

  // R5
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[REG_W-2:CODE_W] == '0);

  // R7
  wr_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> code_o[$past(cfg_idx_i)] == $past(cfg_wdata_i[CODE_W-1:0]));

  // R7
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rd_i |=> $stable(cfg_rdata_o));
endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_steer_pkg::*;
(
  input  logic [NUM_SRC-1:0]              pirq_ni,
  input  logic [NUM_SRC-1:0]              dis_i,
  input  logic [NUM_SRC-1:0][CODE_W-1:0]  code_i,
  output logic [NUM_SRC-1:0][NUM_IRQ-1:0] line_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
    logic hit;
    assign hit = !dis_i[i] && !pirq_ni[i] && code_valid(code_i[i]);
    always_comb begin
      line_o[i] = '0;
      if (hit) line_o[i][code_i[i]] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_steer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  cfg_idx_i,
  input  logic        cfg_wr_i,
  input  logic [7:0]  cfg_wdata_i,
  input  logic        cfg_rd_i,
  output logic [7:0]  cfg_rdata_o,
  input  logic [3:0]  pirq_ni,
  output logic [15:0] irq_o
);
  logic [NUM_SRC-1:0]              dis;
  logic [NUM_SRC-1:0][CODE_W-1:0]  code;
  logic [NUM_SRC-1:0][NUM_IRQ-1:0] line;
  logic [NUM_IRQ-1:0]              irq_d, irq_q;

  irq_route_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rd_i    (cfg_rd_i),
    .cfg_rdata_o (cfg_rdata_o),
    .dis_o       (dis),
    .code_o      (code)
  );

  irq_route_decode u_dec (
    .pirq_ni (pirq_ni),
    .dis_i   (dis),
    .code_i  (code),
    .line_o  (line)
  );

  // shared lines: OR over all sources
  always_comb begin
    irq_d = '0;
    for (int i = 0; i < NUM_SRC; i++) irq_d |= line[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R4
  no_reserved_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~VALID_MASK) == '0);

  // R2
  all_disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&dis) |=> irq_o == '0);

  // R8
  idle_inputs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&pirq_ni) |=> irq_o == '0);
endmodule

// File: tb/irq_steer_router_test.sv
module irq_steer_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  idx = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  pirq_n = 4'hF;
  logic [15:0] irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_steer_router uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_idx_i(idx), .cfg_wr_i(wr),
    .cfg_wdata_i(wdata), .cfg_rd_i(rd), .cfg_rdata_o(rdata),
    .pirq_ni(pirq_n), .irq_o(irq)
  );

  function automatic bit valid_code(input int c);
    case (c)
      3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int i, input logic [7:0] d);
    @(negedge clk); idx = 2'(i); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cfg_read(input int i, output logic [7:0] d);
    @(negedge clk); idx = 2'(i); rd = 1'b1;
    @(posedge clk); #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic drive(input logic [3:0] v);
    @(negedge clk); pirq_n = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int i = 0; i < 4; i++) begin
      cfg_read(i, d);
      check("R1 reset value", {8'h0, d}, 16'h0080);
    end
    drive(4'h0);
    check("R1 reset unrouted", irq, 16'h0);
    drive(4'hF);
  endtask

  task automatic t_valid_codes();
    for (int c = 0; c < 16; c++) begin
      if (!valid_code(c)) continue;
      cfg_write(0, 8'(c));
      drive(4'hE);
      check($sformatf("R3 code %0d asserted", c), irq, 16'(1) << c);
      drive(4'hF);
      check($sformatf("R3 code %0d released", c), irq, 16'h0);
    end
  endtask

  task automatic t_reserved_codes();
    for (int c = 0; c < 16; c++) begin
      if (valid_code(c)) continue;
      cfg_write(0, 8'(c));
      drive(4'hE);
      check($sformatf("R4 reserved code %0d", c), irq, 16'h0);
    end
    drive(4'hF);
  endtask

  task automatic t_disable();
    cfg_write(1, 8'h85);
    drive(4'hD);
    check("R2 disabled route", irq, 16'h0);
    cfg_write(1, 8'h05);
    drive(4'hD);
    check("R2 re-enabled route", irq, 16'h0020);
    cfg_write(1, 8'h80);
    drive(4'hF);
  endtask

  task automatic t_reserved_bits();
    logic [7:0] d;
    cfg_write(2, 8'h7F);
    cfg_read(2, d);
    check("R5 bits 6:4 zero", {8'h0, d}, 16'h000F);
    cfg_write(3, 8'hF3);
    cfg_read(3, d);
    check("R5 disabled readback", {8'h0, d}, 16'h0083);
  endtask

  task automatic t_shared();
    cfg_write(0, 8'h80);
    cfg_write(1, 8'h0A);
    cfg_write(2, 8'h0A);
    cfg_write(3, 8'h0B);
    drive(4'hD); check("R6 B only", irq, 16'h0400);
    drive(4'hB); check("R6 C only", irq, 16'h0400);
    drive(4'h9); check("R6 B and C", irq, 16'h0400);
    drive(4'h1); check("R6 B,C,D", irq, 16'h0C00);
    drive(4'hF); check("R6 none", irq, 16'h0);
  endtask

  task automatic t_read_hold();
    logic [7:0] d;
    cfg_write(0, 8'h09);
    cfg_read(0, d);
    check("R7 read after write", {8'h0, d}, 16'h0009);
    cfg_write(0, 8'h0C);
    repeat (2) @(negedge clk);
    check("R7 held without read", {8'h0, rdata}, 16'h0009);
    cfg_read(0, d);
    check("R7 new read", {8'h0, d}, 16'h000C);
  endtask

  task automatic t_latency();
    cfg_write(0, 8'h07);
    @(negedge clk); pirq_n = 4'hE;
    #1 check("R8 before edge", irq, 16'h0);
    @(posedge clk); #1 check("R8 after edge", irq, 16'h0080);
    @(negedge clk); pirq_n = 4'hF;
    #1 check("R8 hold before release edge", irq, 16'h0080);
    @(posedge clk); #1 check("R8 released", irq, 16'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_valid_codes();
    t_reserved_codes();
    t_disable();
    t_reserved_bits();
    t_shared();
    t_read_hold();
    t_latency();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule